// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front-End

This block sits between a simple single-cycle register port and a serial shift engine. Software configures the serial clock ratio, the clock edges and idle level, the word and data lengths, the bit order and the frame (chip-select) behaviour through a small set of memory-mapped registers. All of these settings are brought straight out to the shift engine as configuration pins. Two eight-word FIFOs buffer outgoing and incoming words. A single data address pushes into the transmit FIFO on a write and pops the receive FIFO on a read.

When the enable bit is set and the transmit FIFO holds a word, the block pops that word and hands it to the shift engine with a one-cycle start pulse. It waits for the engine's done pulse, then stores the returned word in the receive FIFO. Sticky event flags record three things: the receive FIFO reaching its programmed threshold, a received word lost to a full receive FIFO, and the end of the last queued transfer. Each flag is cleared by writing ones to the address it is read from. The receive-threshold and overrun flags can each be routed to a single interrupt line.

Top module: `spi_regfront`

## Requirements
- R1: After reset every register reads zero, the receive FIFO is empty, and `irq`, `cs_level` and `eng_start` are low.
- R2: Register fields read back as written and drive their configuration pins. At 0x04 the fields are ratio [7:0], capture edge bit 14, idle level bit 13 and delay bit 12. At 0x08 they are word length [13:8], bit order [7:6] and transmit data length [5:0]. At 0x0C the receive data length is [5:0]. Interrupt enables sit at 0x18 bits 3 and 0. Bits outside these fields read zero.
- R3: Bit 15 of the frame register (0x10) drives `cs_level` directly from the cycle after the write. Bit 14 is the frame-start edge.
- R4: A write to 0x24 pushes into the transmit FIFO. A write while the FIFO holds 8 words is dropped.
- R5: With enable (0x00 bit 0) set, each queued word is sent in order through one start/done exchange, and each returned word is pushed into the receive FIFO. With enable clear, no start pulse is issued.
- R6: A read of 0x24 returns and pops the oldest receive word, or returns 0 when the FIFO is empty. Status (0x14) bit 0 is 1 exactly while the receive FIFO is not empty.
- R7: At 0x1C, bit 3 is set when a push makes the receive count equal the nonzero receive threshold (0x20 [3:0]). Bit 9 reads 1 while the threshold is nonzero and the count is at or above it.
- R8: A returned word that arrives while the receive FIFO is full sets 0x1C bit 0 and is dropped. If a data read pops in the same cycle, the word is accepted and no overrun is flagged.
- R9: 0x1C bit 4 is set when a transfer completes with the transmit FIFO empty.
- R10: Writing 1 to bit 4, 3 or 0 of 0x1C clears that flag, and writing 0 leaves it unchanged. A flag event in the same cycle as its clear leaves the flag set.
- R11: `irq` is high exactly when (bit 3 flag and enable bit 3) or (bit 0 flag and enable bit 0). The bit 4 flag never drives `irq`.
- R12: At 0x20, writing 1 to bit 12 empties the transmit FIFO and writing 1 to bit 4 empties the receive FIFO, both at the write. Each such bit reads 1 in the following cycle only. The thresholds (0x20 [11:8] and [3:0]) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the current address |
| eng_start | output | 1 | One-cycle start pulse to the shift engine |
| eng_txword | output | DW | Word to shift out |
| eng_done | input | 1 | Shift engine finished a word |
| eng_rxword | input | DW | Word shifted in, valid with eng_done |
| cfg_ratio | output | 8 | Serial clock ratio |
| cfg_capture_edge | output | 1 | Capture edge select |
| cfg_idle_level | output | 1 | Serial clock idle level |
| cfg_delay | output | 1 | Clock delay select |
| cfg_word_len | output | 6 | Word length |
| cfg_bit_order | output | 2 | Bit order format |
| cfg_tx_len | output | 6 | Transmit data length |
| cfg_rx_len | output | 6 | Receive data length |
| cfg_frame_edge | output | 1 | Frame-start edge select |
| cs_level | output | 1 | Chip-select level |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet in one cycle. The first is a returned word from the shift engine arriving while the receive FIFO is full. The second is either a data-port read that pops that FIFO or a write-one clear of the overrun flag. The bench takes the engine side under direct control and drives done in the very cycle the bus pops the full FIFO. It then requires that no overrun is flagged and that the new word lands behind the seven remaining ones. In a second run it drives done together with a clear of the overrun flag and requires that the flag stays set.

// File: rtl/spi_regfront.sv
module spi_regfront #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          eng_start,
  output logic [DW-1:0] eng_txword,
  input  logic          eng_done,
  input  logic [DW-1:0] eng_rxword,
  output logic [7:0]    cfg_ratio,
  output logic          cfg_capture_edge,
  output logic          cfg_idle_level,
  output logic          cfg_delay,
  output logic [5:0]    cfg_word_len,
  output logic [1:0]    cfg_bit_order,
  output logic [5:0]    cfg_tx_len,
  output logic [5:0]    cfg_rx_len,
  output logic          cfg_frame_edge,
  output logic          cs_level,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [AW-1:0] A_CTRL = AW'('h00);
  localparam logic [AW-1:0] A_CLK  = AW'('h04);
  localparam logic [AW-1:0] A_TXW  = AW'('h08);
  localparam logic [AW-1:0] A_RXW  = AW'('h0C);
  localparam logic [AW-1:0] A_FRM  = AW'('h10);
  localparam logic [AW-1:0] A_STAT = AW'('h14);
  localparam logic [AW-1:0] A_IE   = AW'('h18);
  localparam logic [AW-1:0] A_ISC  = AW'('h1C);
  localparam logic [AW-1:0] A_FCTL = AW'('h20);
  localparam logic [AW-1:0] A_DATA = AW'('h24);

  logic          en, fr_pol, fr_edge, ie_rc, ie_ovr;
  logic          fl_rc, fl_ovr, fl_txc, txfl_q, rxfl_q, busy;
  logic [3:0]    tx_th, rx_th;
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, rx_cnt_nx;
  logic          unused_hi;

  assign unused_hi = ^bus_wdata[DW-1:16];

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_clk  = bus_wr && bus_addr == A_CLK;
  wire wr_txw  = bus_wr && bus_addr == A_TXW;
  wire wr_rxw  = bus_wr && bus_addr == A_RXW;
  wire wr_frm  = bus_wr && bus_addr == A_FRM;
  wire wr_ie   = bus_wr && bus_addr == A_IE;
  wire wr_isc  = bus_wr && bus_addr == A_ISC;
  wire wr_fctl = bus_wr && bus_addr == A_FCTL;
  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire rd_data = bus_rd && bus_addr == A_DATA;

  wire tx_flush = wr_fctl && bus_wdata[12];
  wire rx_flush = wr_fctl && bus_wdata[4];
  wire tx_push  = wr_data && tx_cnt != FULL;
  wire tx_pop   = en && !busy && tx_cnt != '0 && !tx_flush;
  wire eng_fin  = busy && eng_done;
  wire rx_pop   = rd_data && rx_cnt != '0 && !rx_flush;
  wire rx_push  = eng_fin && (rx_cnt != FULL || rx_pop) && !rx_flush;
  wire ovr_evt  = eng_fin && rx_cnt == FULL && !rx_pop && !rx_flush;
  wire txc_evt  = eng_fin && tx_cnt == '0;
  assign rx_cnt_nx = rx_cnt + CW'(rx_push) - CW'(rx_pop);
  wire rc_evt   = rx_push && !rx_pop && rx_th != '0 && rx_cnt_nx == CW'(rx_th);
  wire rx_ready = rx_th != '0 && rx_cnt >= CW'(rx_th);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; cfg_ratio <= '0; cfg_capture_edge <= 1'b0; cfg_idle_level <= 1'b0;
      cfg_delay <= 1'b0; cfg_word_len <= '0; cfg_bit_order <= '0; cfg_tx_len <= '0;
      cfg_rx_len <= '0; fr_pol <= 1'b0; fr_edge <= 1'b0; ie_rc <= 1'b0; ie_ovr <= 1'b0;
      tx_th <= '0; rx_th <= '0; txfl_q <= 1'b0; rxfl_q <= 1'b0;
      fl_rc <= 1'b0; fl_ovr <= 1'b0; fl_txc <= 1'b0;
    end else begin
      if (wr_ctrl) en <= bus_wdata[0];
      if (wr_clk) begin
        cfg_ratio        <= bus_wdata[7:0];
        cfg_capture_edge <= bus_wdata[14];
        cfg_idle_level   <= bus_wdata[13];
        cfg_delay        <= bus_wdata[12];
      end
      if (wr_txw) begin
        cfg_word_len  <= bus_wdata[13:8];
        cfg_bit_order <= bus_wdata[7:6];
        cfg_tx_len    <= bus_wdata[5:0];
      end
      if (wr_rxw) cfg_rx_len <= bus_wdata[5:0];
      if (wr_frm) begin
        fr_pol  <= bus_wdata[15];
        fr_edge <= bus_wdata[14];
      end
      if (wr_ie) begin
        ie_rc  <= bus_wdata[3];
        ie_ovr <= bus_wdata[0];
      end
      if (wr_fctl) begin
        tx_th <= bus_wdata[11:8];
        rx_th <= bus_wdata[3:0];
      end
      txfl_q <= tx_flush;
      rxfl_q <= rx_flush;
      fl_rc  <= rc_evt  | (fl_rc  & ~(wr_isc & bus_wdata[3]));
      fl_ovr <= ovr_evt | (fl_ovr & ~(wr_isc & bus_wdata[0]));
      fl_txc <= txc_evt | (fl_txc & ~(wr_isc & bus_wdata[4]));
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= eng_rxword;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; eng_start <= 1'b0; eng_txword <= '0;
    end else begin
      eng_start <= tx_pop;
      if (tx_pop) begin
        busy       <= 1'b1;
        eng_txword <= tx_mem[tx_rp];
      end else if (eng_fin) begin
        busy <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0] = en;
      A_CLK: begin
        bus_rdata[7:0] = cfg_ratio;
        bus_rdata[14]  = cfg_capture_edge;
        bus_rdata[13]  = cfg_idle_level;
        bus_rdata[12]  = cfg_delay;
      end
      A_TXW: begin
        bus_rdata[13:8] = cfg_word_len;
        bus_rdata[7:6]  = cfg_bit_order;
        bus_rdata[5:0]  = cfg_tx_len;
      end
      A_RXW: bus_rdata[5:0] = cfg_rx_len;
      A_FRM: begin
        bus_rdata[15] = fr_pol;
        bus_rdata[14] = fr_edge;
      end
      A_STAT: bus_rdata[0] = rx_cnt != '0;
      A_IE: begin
        bus_rdata[3] = ie_rc;
        bus_rdata[0] = ie_ovr;
      end
      A_ISC: begin
        bus_rdata[9] = rx_ready;
        bus_rdata[4] = fl_txc;
        bus_rdata[3] = fl_rc;
        bus_rdata[0] = fl_ovr;
      end
      A_FCTL: begin
        bus_rdata[12]   = txfl_q;
        bus_rdata[11:8] = tx_th;
        bus_rdata[4]    = rxfl_q;
        bus_rdata[3:0]  = rx_th;
      end
      A_DATA: if (rx_cnt != '0) bus_rdata = rx_mem[rx_rp];
      default: bus_rdata = '0;
    endcase
  end

  assign cfg_frame_edge = fr_edge;
  assign cs_level       = fr_pol;
  assign irq            = (fl_rc & ie_rc) | (fl_ovr & ie_ovr);
endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          eng_start,
  input logic          eng_done,
  input logic          cs_level,
  input logic          irq,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  localparam logic [AW-1:0] C_FRM  = AW'('h10);
  localparam logic [AW-1:0] C_FCTL = AW'('h20);
  localparam logic [AW-1:0] C_DATA = AW'('h24);

  a_r3_cs_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == C_FRM |=> cs_level == $past(bus_wdata[15]));

  a_r5_start_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r4_tx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  a_r8_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == C_DATA && rx_cnt == '0 |-> bus_rdata == '0);

  a_r12_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == C_FCTL && bus_wdata[12] |=> tx_cnt == '0);

  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(eng_done) || $past(bus_wr));
endmodule

bind spi_regfront spi_regfront_chk #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_done(eng_done),
  .cs_level(cs_level), .irq(irq), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_spi_regfront.sv
module test_spi_regfront;
  localparam int CLK_P = 10;
  localparam logic [31:0] MASK = 32'h5A5A_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        eng_start, eng_done = 1'b0;
  logic [31:0] eng_txword, eng_rxword = '0;
  logic [7:0]  cfg_ratio;
  logic        cfg_capture_edge, cfg_idle_level, cfg_delay, cfg_frame_edge, cs_level, irq;
  logic [5:0]  cfg_word_len, cfg_tx_len, cfg_rx_len;
  logic [1:0]  cfg_bit_order;

  int checks = 0, fails = 0, n_starts = 0, wait_c = 0;
  logic manual = 1'b0, pend = 1'b0, done_flag = 1'b0;
  logic [31:0] cap;

  spi_regfront i_spi_regfront (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
    .eng_txword(eng_txword), .eng_done(eng_done), .eng_rxword(eng_rxword),
    .cfg_ratio(cfg_ratio), .cfg_capture_edge(cfg_capture_edge), .cfg_idle_level(cfg_idle_level),
    .cfg_delay(cfg_delay), .cfg_word_len(cfg_word_len), .cfg_bit_order(cfg_bit_order),
    .cfg_tx_len(cfg_tx_len), .cfg_rx_len(cfg_rx_len), .cfg_frame_edge(cfg_frame_edge),
    .cs_level(cs_level), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (eng_start) n_starts++;
    if (!manual) begin
      if (eng_done) eng_done = 1'b0;
      if (eng_start) begin
        pend = 1'b1; cap = eng_txword; wait_c = 2;
      end else if (pend) begin
        if (wait_c == 0) begin
          eng_done = 1'b1; eng_rxword = cap ^ MASK; pend = 1'b0;
        end else wait_c--;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a <= 'h24; a += 4) begin
      rd(6'(a), v); chk($sformatf("R1 reg %0h", a), v, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 cs_level", {31'b0, cs_level}, 0);
    chk("R1 eng_start", {31'b0, eng_start}, 0);
  endtask

  task automatic t_config;
    logic [31:0] v;
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); chk("R2 clk all ones", v, 32'h0000_70FF);
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, v); chk("R2 txw all ones", v, 32'h0000_3FFF);
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, v); chk("R2 rxw all ones", v, 32'h0000_003F);
    wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, v); chk("R2 ie all ones", v, 32'h0000_0009);
    wr(6'h18, 32'h0);
    wr(6'h04, 32'h0000_4012);
    chk("R2 ratio pin", {24'b0, cfg_ratio}, 32'h12);
    chk("R2 edge pins", {29'b0, cfg_capture_edge, cfg_idle_level, cfg_delay}, 32'h4);
    wr(6'h08, 32'h0000_0A45);
    chk("R2 txw pins", {18'b0, cfg_word_len, cfg_bit_order, cfg_tx_len}, {18'b0, 6'h0A, 2'b01, 6'h05});
    wr(6'h0C, 32'h0000_0017);
    chk("R2 rxlen pin", {26'b0, cfg_rx_len}, 32'h17);
  endtask

  task automatic t_cs;
    logic [31:0] v;
    wr(6'h10, 32'h0000_8000);
    chk("R3 cs high", {31'b0, cs_level}, 1);
    rd(6'h10, v); chk("R3 frame readback", v, 32'h8000);
    wr(6'h10, 32'h0000_4000);
    chk("R3 cs low", {31'b0, cs_level}, 0);
    chk("R3 frame edge pin", {31'b0, cfg_frame_edge}, 1);
  endtask

  task automatic t_stream;
    logic [31:0] v;
    int s0;
    s0 = n_starts;
    for (int i = 0; i < 9; i++) wr(6'h24, 32'h100 + i);
    idle(5);
    chk("R5 no start while disabled", n_starts - s0, 0);
    wr(6'h00, 32'h1);
    idle(100);
    chk("R4 ninth word dropped", n_starts - s0, 8);
    rd(6'h1C, v); chk("R9 tx complete only", v, 32'h10);
    rd(6'h14, v); chk("R6 status not empty", v, 32'h1);
    for (int i = 0; i < 8; i++) begin
      rd(6'h24, v); chk($sformatf("R5 rx word %0d", i), v, (32'h100 + i) ^ MASK);
    end
    rd(6'h14, v); chk("R6 status empty", v, 32'h0);
    rd(6'h24, v); chk("R6 empty read zero", v, 32'h0);
    wr(6'h1C, 32'h0); rd(6'h1C, v); chk("R10 write zero keeps", v, 32'h10);
    wr(6'h1C, 32'h10); rd(6'h1C, v); chk("R10 clear tx complete", v, 32'h0);
  endtask

  task automatic t_threshold;
    logic [31:0] v;
    wr(6'h20, 32'h0000_0003);
    wr(6'h18, 32'h8);
    for (int i = 0; i < 3; i++) wr(6'h24, 32'h200 + i);
    idle(40);
    rd(6'h1C, v); chk("R7 threshold reached", v, 32'h218);
    chk("R11 irq on rc", {31'b0, irq}, 1);
    wr(6'h18, 32'h0); chk("R11 irq masked", {31'b0, irq}, 0);
    wr(6'h18, 32'h8); chk("R11 irq unmasked", {31'b0, irq}, 1);
    wr(6'h1C, 32'h8); chk("R10 irq after clear", {31'b0, irq}, 0);
    rd(6'h1C, v); chk("R7 ready level stays", v, 32'h210);
    rd(6'h24, v); chk("R7 first word", v, 32'h200 ^ MASK);
    rd(6'h1C, v); chk("R7 ready below threshold", v, 32'h010);
    wr(6'h18, 32'h9); chk("R11 tx complete no irq", {31'b0, irq}, 0);
    wr(6'h1C, 32'h10);
    rd(6'h24, v); rd(6'h24, v);
  endtask

  task automatic t_overrun;
    logic [31:0] v;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 6'h20; bus_wdata = 32'h0000_0010;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b1; #1 v = bus_rdata;
    chk("R12 flush bit reads one", v, 32'h10);
    @(negedge clk); #1 v = bus_rdata;
    chk("R12 flush bit self clears", v, 32'h0);
    bus_rd = 1'b0;
    wr(6'h18, 32'h1);
    for (int i = 0; i < 8; i++) wr(6'h24, 32'h300 + i);
    idle(60);
    rd(6'h1C, v); chk("R8 full no overrun", v[0], 1'b0);
    chk("R11 irq idle", {31'b0, irq}, 0);
    wr(6'h24, 32'h3FF);
    idle(20);
    rd(6'h1C, v); chk("R8 overrun flagged", v, 32'h11);
    chk("R11 irq on overrun", {31'b0, irq}, 1);
    for (int i = 0; i < 8; i++) begin
      rd(6'h24, v); chk($sformatf("R8 kept word %0d", i), v, (32'h300 + i) ^ MASK);
    end
    rd(6'h14, v); chk("R8 dropped word absent", v, 32'h0);
    wr(6'h1C, 32'h11);
  endtask

  task automatic t_pop_push_same_cycle;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wr(6'h24, 32'h400 + i);
    idle(60);
    manual = 1'b1;
    wr(6'h24, 32'h4FF);
    idle(3);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 6'h24; eng_done = 1'b1; eng_rxword = 32'hC0DE_0009;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; eng_done = 1'b0;
    chk("R8 pop during push word", v, 32'h400 ^ MASK);
    rd(6'h1C, v); chk("R8 no overrun with pop", v[0], 1'b0);
    for (int i = 1; i < 8; i++) begin
      rd(6'h24, v); chk($sformatf("R8 order word %0d", i), v, (32'h400 + i) ^ MASK);
    end
    rd(6'h24, v); chk("R8 late word accepted", v, 32'hC0DE_0009);
    wr(6'h1C, 32'h11);
    manual = 1'b0;
  endtask

  task automatic t_set_beats_clear;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wr(6'h24, 32'h500 + i);
    idle(60);
    manual = 1'b1;
    wr(6'h24, 32'h5FF);
    idle(3);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 6'h1C; bus_wdata = 32'h1; eng_done = 1'b1; eng_rxword = 32'hDEAD_0001;
    @(negedge clk); bus_wr = 1'b0; eng_done = 1'b0;
    rd(6'h1C, v); chk("R10 set wins over clear", v[0], 1'b1);
    wr(6'h1C, 32'h11);
    rd(6'h1C, v); chk("R10 later clear works", v[0], 1'b0);
    wr(6'h20, 32'h10);
    rd(6'h14, v); chk("R12 rx flush empties", v, 32'h0);
    manual = 1'b0;
  endtask

  task automatic t_tx_flush;
    logic [31:0] v;
    int s0;
    wr(6'h00, 32'h0);
    for (int i = 0; i < 3; i++) wr(6'h24, 32'h600 + i);
    wr(6'h20, 32'h0000_1C05);
    rd(6'h20, v); chk("R12 thresholds readback", v, 32'h0C05);
    s0 = n_starts;
    wr(6'h00, 32'h1);
    idle(20);
    chk("R12 tx flush no starts", n_starts - s0, 0);
    rd(6'h14, v); chk("R12 rx still empty", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_config;
    t_cs;
    t_stream;
    t_threshold;
    t_overrun;
    t_pop_push_same_cycle;
    t_set_beats_clear;
    t_tx_flush;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule